// File: doc/BRIEF.md
# Double-Buffered Full-Duplex Serial Master

This block is a serial peripheral master that exchanges 8-bit frames with one slave. Transmit and receive share a single data-register style port. A write stores a byte in a transmit holding buffer. A read takes the byte from a receive buffer. The shift register between the two buffers is separate from both, so the next byte can wait in the holding buffer while the current one is still on the wire.

The serial clock idles high. The outgoing line changes on each falling edge, and the incoming line is sampled on each rising edge. Bits move most significant first. The clock runs at the system clock divided by an even ratio that a divider input selects.

Three status outputs let software keep the link saturated:
- `txe` shows that the holding buffer has room.
- `rxne` shows that a received byte is waiting.
- `bsy` stays high across an unbroken run of frames.

A sticky overrun output records that an unread byte was replaced.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, txe=1, rxne=0, bsy=0, ovr=0, sck=1 and mosi=1.
- R2: sck is high whenever bsy is low. Within a frame, mosi changes only on falling sck edges and miso is taken on rising sck edges. A frame has 8 bits, most significant bit first, and the byte written at frame n appears on mosi during frame n.
- R3: A wr_en pulse makes txe read 0 from the next cycle. When the held byte moves into the shift register, txe reads 1 again from the following cycle.
- R4: A byte written before the 8th rising edge of the current frame starts the next frame with no gap. Consecutive falling sck edges stay exactly 2*(half_div+1) system cycles apart across frame boundaries, and bsy does not drop between those frames.
- R5: The cycle after the 8th rising edge of a frame, rxne reads 1 and rd_data holds the received byte. A rd_en pulse clears rxne from the next cycle. If rd_en and a byte completion fall in the same cycle, rxne stays 1 and rd_data takes the new byte.
- R6: bsy rises the cycle after an idle engine takes a byte from the holding buffer. It falls together with the final rising sck edge of a frame that has no successor byte ready.
- R7: A byte completing while rxne=1, with no rd_en in that cycle, sets ovr. ovr then stays at 1 until reset, and the receive buffer holds the newer byte.
- R8: Each sck half-period lasts half_div+1 system clock cycles.
- R9: While en=0, no new frame starts. A written byte waits in the holding buffer (txe=0, bsy=0, sck high) and is sent once en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new frames to start |
| half_div | input | DIV_W | sck half-period minus one, in system cycles |
| wr_en | input | 1 | Write strobe for the transmit holding buffer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Read strobe; consumes the received byte |
| rd_data | output | DATA_W | Receive buffer contents |
| txe | output | 1 | Transmit holding buffer empty |
| rxne | output | 1 | Receive buffer holds an unread byte |
| bsy | output | 1 | Frames in progress |
| ovr | output | 1 | Sticky overrun |
| sck | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A read of the receive buffer and the arrival of the next complete byte can fall in the same system cycle. When they do, the read must consume the old byte without losing the new one or flagging an overrun. The bench provokes this collision by counting rising sck edges during a two-frame burst and predicting the cycle of the 8th rising edge of the second frame from the half-period. It then pulses rd_en exactly there. The collision is judged correct if rd_data showed the first byte just before the pulse, and if afterwards rxne is still set, rd_data holds the second byte and ovr stays clear.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  // Shift engine phases: idle, sck high awaiting fall, sck low awaiting rise.
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_HIGH = 2'd1,
    ENG_LOW  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_dbuf_tick.sv
module spi_dbuf_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == half_div) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == half_div);

  // With a half-period above one cycle, ticks never come back to back.
  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && half_div != '0) |=> (!tick || !$stable(half_div)));
endmodule

// File: rtl/spi_dbuf_txbuf.sv
module spi_dbuf_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_data <= wr_data;
      hold_full <= 1'b1;
    end else if (pop) begin
      hold_full <= 1'b0;
    end
  end

  assert_txe_clear_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hold_full);
  assert_txe_set_on_load_R3: assert property (@(posedge clk) disable iff (rst)
    (pop && !wr_en) |=> !hold_full);
endmodule

// File: rtl/spi_dbuf_rxbuf.sv
module spi_dbuf_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rxne,
  output logic              ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rxne    <= 1'b0;
      ovr     <= 1'b0;
    end else if (done) begin
      rd_data <= byte_in;
      rxne    <= 1'b1;
      if (rxne && !rd_en) ovr <= 1'b1;
    end else if (rd_en) begin
      rxne <= 1'b0;
    end
  end

  assert_rxne_set_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> rxne);
  assert_rxne_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !done) |=> !rxne);
  assert_ovr_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (done && rxne && !rd_en) |=> ovr);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);
endmodule

// File: rtl/spi_dbuf_engine.sv
module spi_dbuf_engine
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              miso,
  output logic              pop,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi,
  output logic              busy
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_t        state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bitc_q;
  logic              start_ok;
  logic              last_rise;

  assign start_ok  = hold_full && en;
  assign last_rise = (state_q == ENG_LOW) && tick && (bitc_q == LAST_BIT);
  assign pop       = ((state_q == ENG_IDLE) || last_rise) && start_ok;
  assign done      = last_rise;
  assign rx_byte   = {shreg_q[DATA_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      shreg_q <= '0;
      bitc_q  <= '0;
      sck     <= 1'b1;
      mosi    <= 1'b1;
      busy    <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start_ok) begin
            shreg_q <= hold_data;
            bitc_q  <= '0;
            busy    <= 1'b1;
            state_q <= ENG_HIGH;
          end
        end
        ENG_HIGH: begin
          if (tick) begin
            sck     <= 1'b0;
            mosi    <= shreg_q[DATA_W-1];
            state_q <= ENG_LOW;
          end
        end
        ENG_LOW: begin
          if (tick) begin
            sck <= 1'b1;
            if (bitc_q == LAST_BIT) begin
              bitc_q <= '0;
              if (start_ok) begin
                shreg_q <= hold_data;
                state_q <= ENG_HIGH;
              end else begin
                shreg_q <= rx_byte;
                busy    <= 1'b0;
                state_q <= ENG_IDLE;
              end
            end else begin
              shreg_q <= rx_byte;
              bitc_q  <= bitc_q + 1'b1;
              state_q <= ENG_HIGH;
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assert_idle_sck_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck);
  assert_sck_moves_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sck));
  assert_busy_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  assert_busy_chain_R4: assert property (@(posedge clk) disable iff (rst)
    (done && hold_full && en) |=> busy);
  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !en) |=> !busy);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              txe,
  output logic              rxne,
  output logic              bsy,
  output logic              ovr,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic              tick;
  logic              pop;
  logic              done;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] rx_byte;

  spi_dbuf_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .run(bsy), .half_div(half_div), .tick(tick)
  );

  spi_dbuf_txbuf #(.DATA_W(DATA_W)) txbuf_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .hold_data(hold_data), .hold_full(hold_full)
  );

  spi_dbuf_engine #(.DATA_W(DATA_W)) engine_i (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .hold_full(hold_full),
    .hold_data(hold_data), .miso(miso), .pop(pop), .done(done),
    .rx_byte(rx_byte), .sck(sck), .mosi(mosi), .busy(bsy)
  );

  spi_dbuf_rxbuf #(.DATA_W(DATA_W)) rxbuf_i (
    .clk(clk), .rst(rst), .done(done), .byte_in(rx_byte), .rd_en(rd_en),
    .rd_data(rd_data), .rxne(rxne), .ovr(ovr)
  );

  assign txe = !hold_full;
endmodule

// File: tb/spi_dbuf_master_tb_top.sv
`timescale 1ns/1ps
module spi_dbuf_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic [3:0] half_div = 4'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       txe, rxne, bsy, ovr, sck, mosi;
  logic       miso = 1'b1;

  always #2.5 clk = ~clk;

  spi_dbuf_master #(.DATA_W(8), .DIV_W(4)) dut_i (
    .clk(clk), .rst(rst), .en(en), .half_div(half_div), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .txe(txe),
    .rxne(rxne), .bsy(bsy), .ovr(ovr), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0;
  logic [7:0] tx [0:15];
  logic [7:0] sl [0:15];
  logic [7:0] cap [0:15];
  int half = 0, cyc = 0, rises = 0, falls = 0, last_fall = -1;
  int gap_bad = 0, hp_bad = 0, bsy_falls = 0;
  int sl_idx = 0, sl_bit = 0, cap_n = 0, cap_bit = 0;
  logic [7:0] cap_sh = 8'h00;
  logic sck_q = 1'b1, bsy_q = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Slave model and line monitor, evaluated between clock edges.
  initial forever begin
    @(negedge clk);
    cyc++;
    if (sck_q && !sck) begin
      falls++;
      if (last_fall >= 0 && cyc - last_fall != 2 * (half + 1)) gap_bad++;
      last_fall = cyc;
      miso = sl[sl_idx & 15][7 - sl_bit];
      sl_bit++;
      if (sl_bit == 8) begin sl_bit = 0; sl_idx++; end
    end
    if (!sck_q && sck) begin
      rises++;
      if (cyc - last_fall != half + 1) hp_bad++;
      cap_sh = {cap_sh[6:0], mosi};
      cap_bit++;
      if (cap_bit == 8) begin cap[cap_n & 15] = cap_sh; cap_n++; cap_bit = 0; end
    end
    if (bsy_q && !bsy) bsy_falls++;
    sck_q = sck;
    bsy_q = bsy;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  task automatic clear_mon(input int h);
    half = h; half_div = 4'(h);
    last_fall = -1; rises = 0; falls = 0; gap_bad = 0; hp_bad = 0;
    bsy_falls = 0; sl_idx = 0; sl_bit = 0; cap_n = 0; cap_bit = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Back-to-back stream: write whenever txe, read whenever rxne.
  task automatic run_stream(input int n, input int h);
    int sent = 0, got = 0;
    clear_mon(h);
    while (got < n) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      if (txe && sent < n) begin wr_en = 1'b1; wr_data = tx[sent]; sent++; end
      if (rxne) begin
        chk(rd_data == sl[got], "R5 rx byte", rd_data, sl[got]);
        got++; rd_en = 1'b1;
      end
    end
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(cap_n == n, "R2 frame count", cap_n, n);
    for (int i = 0; i < n; i++) chk(cap[i] == tx[i], "R2 mosi byte", cap[i], tx[i]);
    chk(gap_bad == 0, "R4 no gap between frames", gap_bad, 0);
    chk(hp_bad == 0, "R8 half period", hp_bad, 0);
    chk(bsy_falls == 1, "R4 bsy held across stream", bsy_falls, 1);
    chk(ovr == 0 && rxne == 0, "R7 no overrun when read", {ovr, rxne}, 0);
    chk(sck == 1 && bsy == 0, "R2 idle sck high", {sck, bsy}, 2);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(txe == 1, "R1 txe", txe, 1);
    chk(rxne == 0, "R1 rxne", rxne, 0);
    chk(bsy == 0, "R1 bsy", bsy, 0);
    chk(ovr == 0, "R1 ovr", ovr, 0);
    chk(sck == 1, "R1 sck", sck, 1);
    chk(mosi == 1, "R1 mosi", mosi, 1);

    // Single frame: R3 / R6 cycle timing
    clear_mon(1);
    tx[0] = 8'h5C; sl[0] = 8'h93;
    @(negedge clk); wr_en = 1'b1; wr_data = tx[0];
    @(negedge clk); wr_en = 1'b0;
    chk(txe == 0, "R3 txe cleared by write", txe, 0);
    @(negedge clk);
    chk(txe == 1, "R3 txe set at load", txe, 1);
    chk(bsy == 1, "R6 bsy rises after load", bsy, 1);
    while (!rxne) @(negedge clk);
    chk(bsy == 0 && sck == 1, "R6 bsy falls with last rise", {bsy, sck}, 1);
    chk(rd_data == sl[0], "R5 single rx", rd_data, sl[0]);
    chk(cap[0] == tx[0], "R2 single tx", cap[0], tx[0]);
    pulse_read();
    @(negedge clk);
    chk(rxne == 0, "R5 rxne cleared by read", rxne, 0);

    // Sweep of dividers and data patterns
    for (int h = 0; h < 4; h++) begin
      for (int i = 0; i < 3; i++) begin tx[i] = 8'hF1 + 8'(i); sl[i] = 8'hA1 + 8'(i); end
      run_stream(3, h);
      for (int i = 0; i < 6; i++) begin
        tx[i] = 8'(i * 53 + h * 17 + 9);
        sl[i] = ~8'(i * 29 + h * 7);
      end
      if (h == 0) begin tx[0] = 8'h00; sl[0] = 8'hFF; tx[1] = 8'h80; sl[1] = 8'h01; end
      run_stream(6, h);
    end

    // Read colliding with byte completion (R5 / R7)
    for (int h = 0; h < 3; h += 2) begin
      clear_mon(h);
      tx[0] = 8'h3A; tx[1] = 8'hC5; sl[0] = 8'h6E; sl[1] = 8'hB2;
      @(negedge clk); wr_en = 1'b1; wr_data = tx[0];
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk); wr_en = 1'b1; wr_data = tx[1];
      @(negedge clk); wr_en = 1'b0;
      do begin @(negedge clk); #1; end while (rises < 15);
      repeat (2 * (h + 1) - 1) @(negedge clk);
      chk(rxne == 1 && rd_data == sl[0], "R5 first byte before collision", rd_data, sl[0]);
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk(rxne == 1, "R5 rxne kept on collision", rxne, 1);
      chk(rd_data == sl[1], "R5 new byte on collision", rd_data, sl[1]);
      chk(ovr == 0, "R7 no overrun on collision", ovr, 0);
      repeat (2) @(negedge clk);
      pulse_read();
    end

    // Overrun (R7)
    clear_mon(1);
    tx[0] = 8'h11; tx[1] = 8'h22; sl[0] = 8'hE4; sl[1] = 8'h4E;
    @(negedge clk); wr_en = 1'b1; wr_data = tx[0];
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = tx[1];
    @(negedge clk); wr_en = 1'b0;
    while (bsy) @(negedge clk);
    @(negedge clk);
    chk(ovr == 1, "R7 overrun raised", ovr, 1);
    chk(rd_data == sl[1], "R7 newer byte kept", rd_data, sl[1]);
    pulse_read();
    @(negedge clk);
    chk(rxne == 0 && ovr == 1, "R7 overrun sticky", {rxne, ovr}, 1);
    do_reset();
    chk(ovr == 0, "R1 ovr cleared by reset", ovr, 0);

    // Enable gating (R9)
    clear_mon(0);
    tx[0] = 8'h9D; sl[0] = 8'h27;
    en = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = tx[0];
    @(negedge clk); wr_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(bsy == 0 && txe == 0, "R9 held while disabled", {bsy, txe}, 0);
    chk(falls == 0 && sck == 1, "R9 sck quiet while disabled", falls, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk(bsy == 1 && txe == 1, "R9 starts after enable", {bsy, txe}, 3);
    while (!rxne) @(negedge clk);
    chk(rd_data == sl[0] && cap[0] == tx[0], "R9 frame after enable", rd_data, sl[0]);
    pulse_read();

    finish_run();
  end
endmodule